// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block turns a fast system clock into the SCL waveform and phase strobes of an I2C master. A controller above it issues one command at a time (a data bit, a START, a repeated START or a STOP). The block walks the bus through the timed phases of that command and marks the cycles in which the SDA driver may change its level and in which incoming SDA is sampled. It returns to a ready state when the command's last phase ends. It does not decide which commands to issue, and it does not compute the timing values it is given.

Two complete timing sets are supplied, a fast-speed set and a high-speed set, and a select input picks between them. Each set is a 64-bit word of eight 8-bit counts. The counts are measured in pre-scaled ticks of DIV+1 system clocks. A data bit lasts (DIV+1)*(LOW+HIGH+2) + 8 + F clocks, where F is the input glitch-filter delay in clocks. The eight overhead clocks are split into two fixed pads of four. One pad follows SCL rising, together with the filter delay, so that read data is sampled only once the filtered SCL level is valid. The other pad follows SCL falling. The chosen set, the data-hold count and the filter count are all captured when a command is accepted.

Top module: `i2c_timing_gen`

## Requirements
- R1: While reset is applied, and after its release with no command issued, scl_o is 1, rdy is 1 and chg_stb, smp_stb, sda_fall_stb and sda_rise_stb are 0.
- R2: A data bit (cmd_code 0) is accepted only when rdy is 1 and SCL is low. From the acceptance edge, SCL stays low for (LOW+1)*(DIV+1) cycles. It then stays high for F+4+(HIGH+1)*(DIV+1) cycles and then stays low for 4 more cycles before rdy rises. The whole bit therefore takes (DIV+1)*(LOW+HIGH+2)+8+F cycles.
- R3: In the low phase of a data bit or a STOP, chg_stb pulses for one cycle, exactly P*(DIV+1) cycles after the low phase begins. P equals HOLD if HOLD+DSU <= LOW. Otherwise P equals LOW-DSU if DSU <= LOW, and 0 if not. chg_stb is never high while SCL is high.
- R4: smp_stb pulses for one cycle, F+3 cycles after SCL rises in a data bit, while SCL is high.
- R5: A START (cmd_code 1) is accepted only when rdy is 1 and SCL is high. SCL stays high for (SSU+1)*(DIV+1) cycles, with sda_fall_stb in the last of them. SCL then stays high for (SHD+1)*(DIV+1) more cycles, after which SCL goes low and rdy rises in the same cycle.
- R6: A repeated START (cmd_code 2) is accepted only when SCL is low. chg_stb pulses in the first cycle after acceptance. SCL then stays low for (REL+1)*(DIV+1) cycles in total, after which the START sequence of R5 follows.
- R7: A STOP (cmd_code 3) is accepted only when SCL is low. Its low phase matches that of a data bit, including chg_stb. SCL then rises and stays high for (PSU+1)*(DIV+1) cycles, with sda_rise_stb in the last of them. After that, rdy rises and SCL stays high.
- R8: The set selected by hs_sel at the acceptance edge is used for the whole command, as are hold_cnt and filt_cnt. Changing hs_sel, either set word or these counts during a command has no effect on that command. Set word layout: [7:0] DIV, [15:8] LOW, [23:16] HIGH, [31:24] SSU, [39:32] SHD, [47:40] PSU, [55:48] DSU, [63:56] REL.
- R9: A command that does not suit the bus state has no effect. These are a START while SCL is low, and a bit, repeated START or STOP while SCL is high. Any command presented while rdy is 0 also has no effect. In each case no strobe or SCL edge follows, rdy stays 1 and SCL keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command request, taken when rdy is 1 and the command is legal |
| cmd_code | input | 2 | 0 bit, 1 START, 2 repeated START, 3 STOP |
| hs_sel | input | 1 | 1 selects the high-speed timing set |
| fs_set | input | 64 | Fast-speed timing set |
| hs_set | input | 64 | High-speed timing set |
| hold_cnt | input | 8 | Data hold after SCL falls, in ticks |
| filt_cnt | input | 3 | Input glitch-filter delay, in clocks |
| rdy | output | 1 | Idle and able to accept a command |
| scl_o | output | 1 | SCL level: 1 released high, 0 driven low |
| chg_stb | output | 1 | SDA may change in the following cycle |
| smp_stb | output | 1 | Sample SDA now |
| sda_fall_stb | output | 1 | Last cycle of START setup: SDA falls next |
| sda_rise_stb | output | 1 | Last cycle of STOP setup: SDA rises next |

## Verification
The bench builds the block with its default parameters: 8-bit counts, a 3-bit filter field and a 4-cycle edge pad. Under these, every phase length is a short, exactly predictable number of cycles. The programmed values include a divider of 0 and one of 200, a zero low count, and the largest filter delay of 7. They also include data-hold and data-setup values that push the change point into both of its clamped positions. The scoreboard predicts the cycle of every SCL edge, strobe and return to ready. Commands that are illegal or arrive while busy must add no events at all. Timing words that change in the middle of a command must leave its phases untouched.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [1:0] {
    CMD_BIT     = 2'd0,
    CMD_START   = 2'd1,
    CMD_RESTART = 2'd2,
    CMD_STOP    = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE_H = 4'd0,
    ST_IDLE_L = 4'd1,
    ST_LOW    = 4'd2,
    ST_RWAIT  = 4'd3,
    ST_HIGH   = 4'd4,
    ST_FWAIT  = 4'd5,
    ST_REL    = 4'd6,
    ST_SU_STA = 4'd7,
    ST_HD_STA = 4'd8,
    ST_SLOW   = 4'd9,
    ST_SU_STO = 4'd10
  } phase_e;

  // slot index of each count inside a timing-set word
  localparam int FLD_DIV    = 0;
  localparam int FLD_LOW    = 1;
  localparam int FLD_HIGH   = 2;
  localparam int FLD_SU_STA = 3;
  localparam int FLD_HD_STA = 4;
  localparam int FLD_SU_STO = 5;
  localparam int FLD_SU_DAT = 6;
  localparam int FLD_REL    = 7;
  localparam int NUM_FLD    = 8;

endpackage

// File: rtl/i2ct_setlatch.sv
module i2ct_setlatch #(
  parameter int CW = 8,
  parameter int FW = 3,
  parameter int NF = 8,
  localparam int SW = CW * NF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          hs_sel,
  input  logic [SW-1:0] fs_set,
  input  logic [SW-1:0] hs_set,
  input  logic [CW-1:0] hold_in,
  input  logic [FW-1:0] filt_in,
  output logic [SW-1:0] set_q,
  output logic [CW-1:0] hold_q,
  output logic [FW-1:0] filt_q
);

  logic [SW-1:0] set_d;
  logic [CW-1:0] hold_d;
  logic [FW-1:0] filt_d;

  always_comb begin
    set_d  = set_q;
    hold_d = hold_q;
    filt_d = filt_q;
    if (cap) begin
      set_d  = hs_sel ? hs_set : fs_set;
      hold_d = hold_in;
      filt_d = filt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      hold_q <= '0;
      filt_q <= '0;
    end else begin
      set_q  <= set_d;
      hold_q <= hold_d;
      filt_q <= filt_d;
    end
  end

endmodule

// File: rtl/i2ct_prescale.sv
module i2ct_prescale #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] div,
  output logic          tick,
  output logic          tick_first
);

  logic [CW-1:0] pc_q, pc_d;

  assign tick       = (pc_q == div);
  assign tick_first = (pc_q == '0);

  always_comb begin
    if (clr || tick) pc_d = '0;
    else             pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

endmodule

// File: rtl/i2ct_chgpos.sv
module i2ct_chgpos #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] hold,
  input  logic [CW-1:0] dsu,
  input  logic [CW-1:0] low,
  output logic [CW-1:0] pos
);

  logic [CW:0] need;

  always_comb begin
    need = {1'b0, hold} + {1'b0, dsu};
    if (need <= {1'b0, low}) pos = hold;
    else if (dsu <= low)     pos = low - dsu;
    else                     pos = '0;
  end

endmodule

// File: rtl/i2ct_phase_fsm.sv
module i2ct_phase_fsm
  import i2ct_pkg::*;
#(
  parameter int CW  = 8,
  parameter int FW  = 3,
  parameter int PAD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic [CW-1:0] low,
  input  logic [CW-1:0] high,
  input  logic [CW-1:0] su_sta,
  input  logic [CW-1:0] hd_sta,
  input  logic [CW-1:0] su_sto,
  input  logic [CW-1:0] rel,
  input  logic [FW-1:0] filt,
  input  logic [CW-1:0] chg_pos,
  input  logic          tick,
  input  logic          tick_first,
  output logic          move,
  output logic          accept,
  output logic          rdy,
  output logic          scl_o,
  output logic          chg_stb,
  output logic          smp_stb,
  output logic          sda_fall_stb,
  output logic          sda_rise_stb
);

  localparam logic [CW:0] PAD_M1 = (CW+1)'(PAD - 1);

  phase_e      st_q, st_d;
  logic [CW:0] cnt_q, cnt_d;
  logic [CW:0] tgt;
  logic        raw, last, legal;
  cmd_e        cmd;

  assign cmd = cmd_e'(cmd_code);
  assign rdy = (st_q == ST_IDLE_H) || (st_q == ST_IDLE_L);

  always_comb begin
    if (st_q == ST_IDLE_H) legal = (cmd == CMD_START);
    else                   legal = (cmd != CMD_START);
  end
  assign accept = rdy && cmd_valid && legal;

  // length of the current phase: ticks for programmed phases, clocks for pads
  always_comb begin
    raw = 1'b0;
    tgt = '0;
    unique case (st_q)
      ST_LOW, ST_SLOW: tgt = {1'b0, low};
      ST_HIGH:         tgt = {1'b0, high};
      ST_SU_STA:       tgt = {1'b0, su_sta};
      ST_HD_STA:       tgt = {1'b0, hd_sta};
      ST_SU_STO:       tgt = {1'b0, su_sto};
      ST_REL:          tgt = {1'b0, rel};
      ST_RWAIT: begin
        raw = 1'b1;
        tgt = (CW+1)'(filt) + PAD_M1;
      end
      ST_FWAIT: begin
        raw = 1'b1;
        tgt = PAD_M1;
      end
      default: tgt = '0;
    endcase
    last = raw ? (cnt_q == tgt) : (tick && (cnt_q == tgt));
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE_H: if (accept) st_d = ST_SU_STA;
      ST_IDLE_L: begin
        if (accept) begin
          unique case (cmd)
            CMD_BIT:     st_d = ST_LOW;
            CMD_RESTART: st_d = ST_REL;
            CMD_STOP:    st_d = ST_SLOW;
            default:     st_d = ST_IDLE_L;
          endcase
        end
      end
      ST_LOW:    if (last) st_d = ST_RWAIT;
      ST_RWAIT:  if (last) st_d = ST_HIGH;
      ST_HIGH:   if (last) st_d = ST_FWAIT;
      ST_FWAIT:  if (last) st_d = ST_IDLE_L;
      ST_REL:    if (last) st_d = ST_SU_STA;
      ST_SU_STA: if (last) st_d = ST_HD_STA;
      ST_HD_STA: if (last) st_d = ST_IDLE_L;
      ST_SLOW:   if (last) st_d = ST_SU_STO;
      ST_SU_STO: if (last) st_d = ST_IDLE_H;
      default:   st_d = ST_IDLE_H;
    endcase
  end

  assign move = (st_d != st_q);

  always_comb begin
    if (move || rdy)       cnt_d = '0;
    else if (raw || tick)  cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE_H;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE_H, ST_RWAIT, ST_HIGH, ST_SU_STA, ST_HD_STA, ST_SU_STO: scl_o = 1'b1;
      default: scl_o = 1'b0;
    endcase
  end

  assign chg_stb = (((st_q == ST_LOW) || (st_q == ST_SLOW)) && tick_first &&
                    (cnt_q == {1'b0, chg_pos})) ||
                   ((st_q == ST_REL) && tick_first && (cnt_q == '0));
  assign smp_stb      = (st_q == ST_RWAIT)  && last;
  assign sda_fall_stb = (st_q == ST_SU_STA) && last;
  assign sda_rise_stb = (st_q == ST_SU_STO) && last;

endmodule

// File: rtl/i2c_timing_gen.sv
module i2c_timing_gen
  import i2ct_pkg::*;
#(
  parameter int CW  = 8,
  parameter int FW  = 3,
  parameter int PAD = 4,
  localparam int SW = CW * NUM_FLD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic          hs_sel,
  input  logic [SW-1:0] fs_set,
  input  logic [SW-1:0] hs_set,
  input  logic [CW-1:0] hold_cnt,
  input  logic [FW-1:0] filt_cnt,
  output logic          rdy,
  output logic          scl_o,
  output logic          chg_stb,
  output logic          smp_stb,
  output logic          sda_fall_stb,
  output logic          sda_rise_stb
);

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic [SW-1:0] set_q;
  logic [CW-1:0] hold_q;
  logic [FW-1:0] filt_q;
  logic [CW-1:0] fld [NUM_FLD];
  logic [CW-1:0] chg_pos;
  logic          tick, tick_first, move, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  i2ct_setlatch #(.CW(CW), .FW(FW), .NF(NUM_FLD)) u_set (
    .clk(clk), .rst_n(rst_i_n), .cap(accept), .hs_sel(hs_sel),
    .fs_set(fs_set), .hs_set(hs_set), .hold_in(hold_cnt), .filt_in(filt_cnt),
    .set_q(set_q), .hold_q(hold_q), .filt_q(filt_q)
  );

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign fld[i] = set_q[i*CW +: CW];
  end

  i2ct_prescale #(.CW(CW)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .clr(move), .div(fld[FLD_DIV]),
    .tick(tick), .tick_first(tick_first)
  );

  i2ct_chgpos #(.CW(CW)) u_pos (
    .hold(hold_q), .dsu(fld[FLD_SU_DAT]), .low(fld[FLD_LOW]), .pos(chg_pos)
  );

  i2ct_phase_fsm #(.CW(CW), .FW(FW), .PAD(PAD)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .low(fld[FLD_LOW]), .high(fld[FLD_HIGH]), .su_sta(fld[FLD_SU_STA]),
    .hd_sta(fld[FLD_HD_STA]), .su_sto(fld[FLD_SU_STO]), .rel(fld[FLD_REL]),
    .filt(filt_q), .chg_pos(chg_pos), .tick(tick), .tick_first(tick_first),
    .move(move), .accept(accept), .rdy(rdy), .scl_o(scl_o),
    .chg_stb(chg_stb), .smp_stb(smp_stb),
    .sda_fall_stb(sda_fall_stb), .sda_rise_stb(sda_rise_stb)
  );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic rdy,
  input logic scl_o,
  input logic chg_stb,
  input logic smp_stb,
  input logic sda_fall_stb,
  input logic sda_rise_stb
);

  p_chg_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> !scl_o);

  p_smp_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> scl_o);

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_stb, smp_stb, sda_fall_stb, sda_rise_stb}));

  p_fall_then_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_fall_stb |=> (scl_o && !rdy));

  p_rise_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_rise_stb |=> (scl_o && rdy));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !cmd_valid) |=> (rdy && $stable(scl_o)));

endmodule

bind i2c_timing_gen i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .rdy(rdy), .scl_o(scl_o),
  .chg_stb(chg_stb), .smp_stb(smp_stb),
  .sda_fall_stb(sda_fall_stb), .sda_rise_stb(sda_rise_stb)
);

// File: tb/sim_i2c_timing_gen.sv
module sim_i2c_timing_gen;
  localparam int CW = 8;
  localparam int FW = 3;
  localparam int SW = CW * 8;
  localparam int EV_CHG = 0, EV_SMP = 1, EV_SF = 2, EV_SR = 3,
                 EV_SU = 4, EV_SD = 5, EV_RDY = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cmd_valid, hs_sel;
  logic [1:0]    cmd_code;
  logic [SW-1:0] fs_set, hs_set;
  logic [CW-1:0] hold_cnt;
  logic [FW-1:0] filt_cnt;
  logic rdy, scl_o, chg_stb, smp_stb, sda_fall_stb, sda_rise_stb;

  i2c_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .hs_sel(hs_sel), .fs_set(fs_set), .hs_set(hs_set), .hold_cnt(hold_cnt),
    .filt_cnt(filt_cnt), .rdy(rdy), .scl_o(scl_o), .chg_stb(chg_stb),
    .smp_stb(smp_stb), .sda_fall_stb(sda_fall_stb), .sda_rise_stb(sda_rise_stb)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int code; int stamp; string req; } ev_t;
  ev_t q[$];
  int errs = 0, checks = 0;
  int b_fld [2][8];
  int b_hold, b_filt;
  bit mon_on = 1'b0, fin = 1'b0;
  logic p_scl = 1'b1, p_rdy = 1'b1;

  // slot order: DIV, LOW, HIGH, SSU, SHD, PSU, DSU, REL
  function automatic logic [SW-1:0] pack(int s);
    logic [SW-1:0] w;
    for (int i = 0; i < 8; i++) w[i*CW +: CW] = CW'(b_fld[s][i]);
    return w;
  endfunction

  task automatic apply();
    fs_set = pack(0); hs_set = pack(1);
    hold_cnt = CW'(b_hold); filt_cnt = FW'(b_filt);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int code, int stamp, string req);
    ev_t e;
    e.code = code; e.stamp = stamp; e.req = req;
    q.push_back(e);
  endtask

  function automatic int cpos(int s);
    int lo = b_fld[s][1], su = b_fld[s][6];
    if (b_hold + su <= lo) return b_hold;
    if (su <= lo) return lo - su;
    return 0;
  endfunction

  task automatic got(int code);
    ev_t e;
    if (q.size() == 0) begin
      chk(1'b0, "R9", $sformatf("unexpected event %0d at cycle", code), cyc, -1);
    end else begin
      e = q.pop_front();
      chk(e.code == code, e.req, $sformatf("event code at cycle %0d", cyc), code, e.code);
      chk(e.stamp == cyc, e.req, $sformatf("cycle of event %0d", code), cyc, e.stamp);
    end
  endtask

  // monitor: events in a fixed order within one cycle
  always @(negedge clk) begin
    if (mon_on) begin
      if (chg_stb)         got(EV_CHG);
      if (smp_stb)         got(EV_SMP);
      if (sda_fall_stb)    got(EV_SF);
      if (sda_rise_stb)    got(EV_SR);
      if (scl_o && !p_scl) got(EV_SU);
      if (!scl_o && p_scl) got(EV_SD);
      if (rdy && !p_rdy)   got(EV_RDY);
    end
    p_scl = scl_o;
    p_rdy = rdy;
  end

  // driver: predicts every event of the command, then presents it
  task automatic issue(int code, int s, bit legal);
    int a, d1, lc, hc, sc, hs, rc, oc, f;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    a  = cyc + 1;
    d1 = b_fld[s][0] + 1;
    lc = (b_fld[s][1] + 1) * d1;
    hc = (b_fld[s][2] + 1) * d1;
    sc = (b_fld[s][3] + 1) * d1;
    hs = (b_fld[s][4] + 1) * d1;
    oc = (b_fld[s][5] + 1) * d1;
    rc = (b_fld[s][7] + 1) * d1;
    f  = b_filt;
    if (legal) begin
      case (code)
        0: begin
          push(EV_CHG, a + cpos(s) * d1, "R3");
          push(EV_SU,  a + lc, "R2");
          push(EV_SMP, a + lc + f + 3, "R4");
          push(EV_SD,  a + lc + f + 4 + hc, "R2");
          push(EV_RDY, a + lc + f + 4 + hc + 4, "R2");
        end
        1: begin
          push(EV_SF,  a + sc - 1, "R5");
          push(EV_SD,  a + sc + hs, "R5");
          push(EV_RDY, a + sc + hs, "R5");
        end
        2: begin
          push(EV_CHG, a, "R6");
          push(EV_SU,  a + rc, "R6");
          push(EV_SF,  a + rc + sc - 1, "R6");
          push(EV_SD,  a + rc + sc + hs, "R6");
          push(EV_RDY, a + rc + sc + hs, "R6");
        end
        default: begin
          push(EV_CHG, a + cpos(s) * d1, "R7");
          push(EV_SU,  a + lc, "R7");
          push(EV_SR,  a + lc + oc - 1, "R7");
          push(EV_RDY, a + lc + oc, "R7");
        end
      endcase
    end
    hs_sel = s[0]; cmd_code = 2'(code); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_rdy();
    while (!rdy) @(negedge clk);
  endtask

  task automatic quiet_check(logic scl_exp, string what);
    repeat (20) @(negedge clk);
    chk(rdy == 1'b1, "R9", {what, " rdy"}, int'(rdy), 1);
    chk(scl_o == scl_exp, "R9", {what, " scl"}, int'(scl_o), int'(scl_exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    b_fld[0] = '{1, 4, 3, 2, 3, 2, 1, 2};
    b_fld[1] = '{0, 2, 1, 1, 1, 1, 0, 1};
    b_hold = 1; b_filt = 2;
    apply();
    cmd_valid = 1'b0; cmd_code = 2'd0; hs_sel = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1, "R1", "scl in reset", int'(scl_o), 1);
    chk(rdy == 1'b1, "R1", "rdy in reset", int'(rdy), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_o == 1'b1, "R1", "scl after reset", int'(scl_o), 1);
    chk(rdy == 1'b1, "R1", "rdy after reset", int'(rdy), 1);
    chk({chg_stb, smp_stb, sda_fall_stb, sda_rise_stb} == 4'b0, "R1", "strobes after reset",
        int'({chg_stb, smp_stb, sda_fall_stb, sda_rise_stb}), 0);
    mon_on = 1'b1;

    issue(1, 0, 1'b1); wait_rdy();                    // R5 START fast set
    issue(0, 0, 1'b1); wait_rdy();                    // R2 bit fast set
    issue(0, 1, 1'b1); wait_rdy();                    // R8 bit high-speed set
    issue(1, 0, 1'b0); quiet_check(1'b0, "START with SCL low");   // R9
    issue(2, 0, 1'b1); wait_rdy();                    // R6 repeated START

    issue(0, 1, 1'b1);                                // R8 changes mid-command
    hs_sel = 1'b0; hs_set = '1; hold_cnt = '1; filt_cnt = '1;
    wait_rdy(); apply();

    b_hold = 4; b_filt = 7; apply();                  // R3 clamp to LOW-DSU, R4 max filter
    issue(0, 0, 1'b1); wait_rdy();
    b_fld[0][6] = 5; apply();                         // R3 DSU above LOW: position 0
    issue(0, 0, 1'b1); wait_rdy();

    issue(3, 0, 1'b1); wait_rdy();                    // R7 STOP
    issue(0, 0, 1'b0); quiet_check(1'b1, "bit with SCL high");       // R9
    issue(2, 0, 1'b0); quiet_check(1'b1, "restart with SCL high");   // R9
    issue(3, 0, 1'b0); quiet_check(1'b1, "stop with SCL high");      // R9

    b_fld[0] = '{200, 1, 1, 0, 0, 0, 0, 0};
    b_hold = 1; b_filt = 0; apply();
    issue(1, 0, 1'b1); wait_rdy();                    // R5 large divider
    issue(0, 0, 1'b1);                                // R9 command while busy
    repeat (10) @(negedge clk);
    cmd_code = 2'd3; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    wait_rdy(); quiet_check(1'b0, "stop while busy");

    b_fld[1] = '{0, 0, 2, 0, 0, 3, 0, 0};
    b_hold = 0; apply();
    issue(0, 1, 1'b1); wait_rdy();                    // R2 zero LOW, divider 0
    issue(3, 1, 1'b1); wait_rdy();                    // R7 STOP high-speed

    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R2", "pending expected events", q.size(), 0);
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule